// File: doc/BRIEF.md
# Three-Lane 7:1 Serializer with Forwarded Clock Lane

This block turns a 21-bit parallel word into three serial bit streams and one forwarded clock stream. The block runs entirely on a bit clock at seven times the word rate. The clock-multiplying loop that makes this clock is outside the block. A one-cycle `word_tick` pulse from that loop marks each word-clock rising edge. On that pulse the whole input word is captured. One word period later, the word is split into three 7-bit slices. Each slice is parallel-loaded into its own shift register, and each register sends its slice one bit per cycle.

A fourth shift register carries a fixed 7-bit pattern: high for four bit times, then low for three. It is reloaded every word, so the clock lane toggles at the word rate. Its rising edge lines up with the first bit of every slice, which lets a receiver recover framing. A shutdown input holds all outputs low at once and stops capture. After release, the outputs stay idle until a complete word has been captured and loaded.

Top module: `ser7_tx`

## Requirements
- R1: The data word is captured only at a clock edge where `word_tick` is high; data present at any other edge has no effect on the transmitted words.
- R2: Lane k carries captured bits 7k through 7k+6, least significant bit first. The first bit appears in the cycle after the load edge.
- R3: The clock lane shows the pattern 1,1,1,1,0,0,0 (high for 4 bit times, then low for 3) in every word period. Its rising edge coincides with bit 0 of every lane's slice.
- R4: A modulo-7 bit counter is cleared by `word_tick` and produces one load strobe when it reaches 6. With `word_tick` every 7 cycles, successive slices follow back to back, exactly 7 cycles apart, with no gap or repeated bit.
- R5: While `shutdown` is high, every `lane_out` bit and `clk_lane` are 0 in the same cycle, and no word is captured.
- R6: After `shutdown` falls, all outputs stay 0 until a word has been captured on `word_tick` and then loaded at the next count of 6.
- R7: `view_word` holds the word currently being shifted out: lane k's loaded slice sits at bits 7k..7k+6.
- R8: After synchronous reset, all serial outputs are 0 and `view_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the word rate |
| rst | input | 1 | Synchronous reset, active high |
| shutdown | input | 1 | Forces idle outputs and halts capture |
| word_tick | input | 1 | One-cycle pulse marking each word-clock rising edge |
| data_in | input | 21 | Parallel word to transmit |
| lane_out | output | 3 | Serial data lanes, bit k is lane k |
| clk_lane | output | 1 | Forwarded word-rate clock pattern |
| view_word | output | 21 | Parallel test view of the slices being shifted |

## Verification
The bench builds the block with its default values: three lanes, 7-bit slices and four high bit times on the clock lane. With these values, every one of the 21 bit positions can be driven by walking ones and walking zeros, followed by dense and pseudo-random words. The bench reassembles each word from the three streams, using the clock-lane rising edge as the frame marker, and checks the spacing between frames. Between ticks it drives garbage on the data input. It also places a shutdown in the middle of a stream, so that the idle phase and the re-arm phase are both observed at the pins.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } ser_state_e;

  // Frame pattern for the clock lane, LSB is sent first: hi_bits ones then zeros.
  function automatic logic [31:0] frame_pattern(input int unsigned hi_bits);
    logic [31:0] p;
    p = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < hi_bits) p[i] = 1'b1;
    end
    return p;
  endfunction

  // Next value of a modulo counter that is re-aligned by a sync pulse.
  function automatic int unsigned mod_next(input int unsigned cur,
                                           input int unsigned modulus,
                                           input logic sync);
    if (sync) return 0;
    if (cur + 1 >= modulus) return 0;
    return cur + 1;
  endfunction

endpackage

// File: rtl/ser7_bitcnt.sv
module ser7_bitcnt #(
  parameter int unsigned SLICE = 7,
  localparam int unsigned CW = (SLICE > 1) ? $clog2(SLICE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  import ser7_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(SLICE - 1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= CW'(mod_next(int'(cnt), SLICE, sync));
  end

  assign wrap = (cnt == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R4
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync |=> (cnt == '0)); // R4

endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] par_in,
  output logic         ser_out,
  output logic [W-1:0] par_view
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr_q     <= '0;
      par_view <= '0;
    end else if (load) begin
      sr_q     <= par_in;
      par_view <= par_in;
    end else begin
      sr_q <= {1'b0, sr_q[W-1:1]};
    end
  end

  assign ser_out = sr_q[0];

  AST_LOAD_LSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (ser_out == $past(par_in[0]))); // R2
  AST_VIEW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr) |=> $stable(par_view)); // R7

endmodule

// File: rtl/ser7_tx.sv
module ser7_tx #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned SLICE  = 7,
  parameter int unsigned CLK_HI = 4,
  localparam int unsigned WORD_W = LANES * SLICE,
  localparam int unsigned CW = (SLICE > 1) ? $clog2(SLICE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shutdown,
  input  logic              word_tick,
  input  logic [WORD_W-1:0] data_in,
  output logic [LANES-1:0]  lane_out,
  output logic              clk_lane,
  output logic [WORD_W-1:0] view_word
);
  import ser7_pkg::*;

  localparam logic [SLICE-1:0] FRAME = SLICE'(frame_pattern(CLK_HI));

  logic [WORD_W-1:0] cap_q;
  ser_state_e        state_q;
  logic [CW-1:0]     bit_cnt;
  logic              bit_wrap;
  logic              load_stb;
  logic              run_state;
  logic              out_en;
  logic              capture_ev;
  logic [LANES-1:0]  lane_raw;
  logic              clk_raw;
  logic [SLICE-1:0]  clk_view;

  assign capture_ev = word_tick && !shutdown;
  assign load_stb   = bit_wrap && (state_q != ST_OFF) && !shutdown;
  assign run_state  = (state_q == ST_RUN);
  assign out_en     = run_state && !shutdown;

  // Word capture register (word-clock rising edge)
  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else if (capture_ev) cap_q <= data_in;
  end

  // Arm / run sequencing
  always_ff @(posedge clk) begin
    if (rst || shutdown) begin
      state_q <= ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   if (capture_ev) state_q <= ST_ARMED;
        ST_ARMED: if (load_stb)   state_q <= ST_RUN;
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  ser7_bitcnt #(.SLICE(SLICE)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .sync (word_tick),
    .cnt  (bit_cnt),
    .wrap (bit_wrap)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLICE-1:0] slice_view;
    ser7_lane #(.W(SLICE)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .clr      (shutdown),
      .load     (load_stb),
      .par_in   (cap_q[k*SLICE +: SLICE]),
      .ser_out  (lane_raw[k]),
      .par_view (slice_view)
    );
    assign view_word[k*SLICE +: SLICE] = slice_view;
    assign lane_out[k] = lane_raw[k] && out_en;
  end

  ser7_lane #(.W(SLICE)) u_clk_lane (
    .clk      (clk),
    .rst      (rst),
    .clr      (shutdown),
    .load     (load_stb),
    .par_in   (FRAME),
    .ser_out  (clk_raw),
    .par_view (clk_view)
  );

  assign clk_lane = clk_raw && out_en;

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !word_tick |=> $stable(cap_q)); // R1
  AST_CLK_MARK: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (clk_lane || shutdown)); // R3
  AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb); // R4
  AST_SD_IDLE: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> (lane_out == '0 && !clk_lane)); // R5
  AST_RUN_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(run_state) |-> $past(load_stb)); // R6
  AST_FRAME_CONST: assert property (@(posedge clk) disable iff (rst)
    $past(load_stb) && !$past(shutdown) |-> (clk_view == FRAME)); // R3

endmodule

// File: tb/ser7_tx_test.sv
module ser7_tx_test;
  localparam int LANES = 3;
  localparam int SLICE = 7;
  localparam int CLK_HI = 4;
  localparam int WW = LANES * SLICE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shutdown = 1'b0;
  logic word_tick = 1'b0;
  logic [WW-1:0] data_in = '0;
  logic [LANES-1:0] lane_out;
  logic clk_lane;
  logic [WW-1:0] view_word;

  ser7_tx #(.LANES(LANES), .SLICE(SLICE), .CLK_HI(CLK_HI)) uut (
    .clk(clk), .rst(rst), .shutdown(shutdown), .word_tick(word_tick),
    .data_in(data_in), .lane_out(lane_out), .clk_lane(clk_lane),
    .view_word(view_word)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  logic [WW-1:0] exp_q [0:255];
  int wr = 0;
  int rd = 0;
  logic [WW-1:0] garbage = 21'h15A3C7;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: reassemble words framed by the clock-lane rising edge
  bit prev_clk = 1'b0;
  bit collecting = 1'b0;
  bit have_last = 1'b0;
  bit idle_watch = 1'b0;
  int idx = 0;
  int cyc = 0;
  int last_start = 0;
  logic [WW-1:0] acc = '0;

  always @(negedge clk) begin
    cyc++;
    if (idle_watch) begin
      chk(lane_out == '0 && !clk_lane, "R6 idle after release",
          {28'd0, clk_lane, lane_out}, 32'd0);
    end
    if (rst || shutdown) begin
      collecting = 1'b0;
      have_last = 1'b0;
      prev_clk = 1'b0;
    end else begin
      if (clk_lane && !prev_clk) begin
        if (have_last)
          chk(cyc - last_start == SLICE, "R4 frame spacing",
              cyc - last_start, SLICE);
        have_last = 1'b1;
        last_start = cyc;
        collecting = 1'b1;
        idx = 0;
      end
      if (collecting) begin
        chk(clk_lane == (idx < CLK_HI), "R3 clock lane pattern",
            {31'd0, clk_lane}, {31'd0, idx < CLK_HI});
        for (int l = 0; l < LANES; l++) acc[l*SLICE + idx] = lane_out[l];
        if (idx == SLICE - 1) begin
          collecting = 1'b0;
          if (rd < wr) begin
            chk(acc == exp_q[rd], "R1 R2 reassembled word", acc, exp_q[rd]);
            chk(view_word == exp_q[rd], "R7 parallel view", view_word, exp_q[rd]);
            rd++;
          end
        end else begin
          idx++;
        end
      end
      prev_clk = clk_lane;
    end
  end

  task automatic send_word(input logic [WW-1:0] w, input bit expect_it);
    @(posedge clk); #1;
    word_tick = 1'b1;
    data_in = w;
    if (expect_it) begin
      exp_q[wr] = w;
      wr++;
    end
    for (int i = 0; i < SLICE - 1; i++) begin
      @(posedge clk); #1;
      word_tick = 1'b0;
      garbage = {garbage[WW-2:0], garbage[WW-1] ^ garbage[1]};
      data_in = garbage;
    end
  endtask

  initial begin
    logic [WW-1:0] lfsr;
    repeat (4) @(posedge clk);
    #1;
    chk(lane_out == '0 && !clk_lane, "R8 reset outputs", {28'd0, clk_lane, lane_out}, 0);
    chk(view_word == '0, "R8 reset view", view_word, 0);
    rst = 1'b0;

    // Walking ones and walking zeros over every bit position
    for (int b = 0; b < WW; b++) send_word(WW'(1) << b, 1'b1);
    for (int b = 0; b < WW; b++) send_word(~(WW'(1) << b), 1'b1);
    send_word('0, 1'b1);
    send_word('1, 1'b1);
    send_word(21'h0AAAAA, 1'b1);
    send_word(21'h155555, 1'b1);
    lfsr = 21'h1F00D3;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[WW-2:0], lfsr[WW-1] ^ lfsr[18]};
      send_word(lfsr, 1'b1);
    end

    // Shutdown mid-stream
    @(posedge clk); #1;
    shutdown = 1'b1;
    rd = wr;
    for (int i = 0; i < 14; i++) begin
      word_tick = (i % SLICE) == 0;
      data_in = WW'(i * 977);
      @(negedge clk);
      chk(lane_out == '0 && !clk_lane, "R5 idle in shutdown",
          {28'd0, clk_lane, lane_out}, 0);
      @(posedge clk); #1;
    end
    word_tick = 1'b0;
    shutdown = 1'b0;
    idle_watch = 1'b1;
    send_word(21'h123456, 1'b1);
    idle_watch = 1'b0;
    send_word(21'h0F0F0F, 1'b1);
    send_word(21'h1ABCDE, 1'b1);

    repeat (3 * SLICE) @(posedge clk);
    #1;
    chk(rd == wr, "R4 all words delivered", rd, wr);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule